// File: doc/BRIEF.md
# Hit timestamp and duration pixel

This block is the digital back end of one detector pixel (or one group of pixels sharing a local oscillator). For each hit it records two quantities together. The arrival time is a coarse reference-period stamp plus a fine sub-period field measured with a fast local clock. The duration is the number of reference edges during which the discriminator stays high. A third quantity, the number of hit edges seen since the previous result, can replace either of them. A 2-bit pairing select chooses which two quantities go into the word.

The whole block runs on the fast clock. The fast clock is phase-aligned with the reference clock and runs 2^FINE_W times faster. The reference clock comes in as a one-cycle edge strobe, and the shared free-running coarse counter comes in as a bus. When a hit ends, the block latches one result word and raises a ready flag. The flag holds until readout acknowledges it, so results leave the pixel event by event and not as a frame. While a result waits, new hits start no measurement. The fine counter asks for the oscillator only while it is measuring.

Top module: `toa_tot_pixel`

## Requirements
- R1: After reset, ready_o, osc_req_o and data_o are all zero.
- R2: A hit is accepted when hit_i is high in a cycle, was low in the cycle before, and the block is idle. Let n be the number of fast cycles from that cycle to the first cycle at or after it with ref_edge_i high (0 to 2^FINE_W-1). The fine arrival field, in the low FINE_W bits of the arrival value, equals 2^FINE_W-1-n.
- R3: The upper COARSE_W bits of the arrival value equal coarse_i as sampled in that reference-edge cycle.
- R4: The duration value counts the cycles with both ref_edge_i and hit_i high, from the accepting cycle up to the end of the hit. It saturates at 2^TOT_W-1 and does not wrap.
- R5: The event value counts hit_i rising edges since the previous result word, including the accepting edge and any ignored edges. It saturates at 2^CNT_W-1 and restarts from zero when a word is latched.
- R6: The hit ends in the first cycle with hit_i low that comes after the arrival reference edge. From the next cycle on, ready_o is high and data_o holds the new word.
- R7: While ready_o is high and ack_i is low, ready_o stays high and data_o does not change. When ack_i is high, ready_o is low in the following cycle.
- R8: Hit edges that occur while ready_o is high start no measurement and leave data_o unchanged.
- R9: osc_req_o is high from the cycle after an accepted hit up to and including the reference-edge cycle that ends the fine count. It is low at all other times, including when the hit coincides with a reference edge.
- R10: data_o = {pair[1:0], hi[HI_W-1:0], lo[LO_W-1:0]}. Here pair is mode_i sampled when the hit ends, and every field is zero-extended. Pair 0 and pair 3 give hi = arrival, lo = duration. Pair 1 gives hi = arrival, lo = events. Pair 2 gives hi = duration, lo = events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local clock, 2^FINE_W times the reference rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_edge_i | input | 1 | One-cycle strobe marking each reference clock edge |
| coarse_i | input | COARSE_W | Shared free-running coarse time counter |
| hit_i | input | 1 | Discriminator output, sampled on clk_i |
| mode_i | input | 2 | Pairing select for the result word |
| ack_i | input | 1 | Readout acknowledge |
| osc_req_o | output | 1 | Request to run the shared fast oscillator |
| ready_o | output | 1 | Result word waiting for readout |
| data_o | output | 2+HI_W+LO_W | Result word |

## Verification
The bench builds the block with COARSE_W=8, FINE_W=4, TOT_W=6 and CNT_W=3. With these values a hit of about a thousand cycles saturates the duration counter. Nine ignored edges saturate the event counter. An idle stretch of 4096 cycles wraps the coarse counter, so a late arrival value shows that the coarse bits follow the counter through the wrap. Every phase of the hit relative to the reference strobe is covered, including a hit on the strobe itself and a hit that ends before its arrival edge.

// File: rtl/toa_tot_pkg.sv
package toa_tot_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARR, ST_DUR, ST_HOLD} pix_st_e;
  typedef enum logic [1:0] {
    PAIR_TOA_TOT = 2'd0,
    PAIR_TOA_CNT = 2'd1,
    PAIR_TOT_CNT = 2'd2,
    PAIR_ALT     = 2'd3
  } pair_e;
endpackage

// File: rtl/tdc_fine.sv
module tdc_fine #(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 4,
  localparam int TOA_W   = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                ref_edge_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic                done_o,
  output logic                osc_req_o,
  output logic [TOA_W-1:0]    toa_o
);
  logic              busy_q;
  logic [FINE_W-1:0] cnt_q;
  logic [TOA_W-1:0]  toa_q;

  assign done_o    = (start_i | busy_q) & ref_edge_i;
  assign osc_req_o = busy_q;
  assign toa_o     = toa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      toa_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      // complement: value grows with position inside the period
      toa_q  <= {coarse_i, ~(busy_q ? cnt_q : {FINE_W{1'b0}})};
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= FINE_W'(1);
    end else if (busy_q) begin
      cnt_q  <= cnt_q + FINE_W'(1);
    end
  end

  // R9
  osc_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i) && !$past(ref_edge_i));
  // R9
  osc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && ref_edge_i |=> !busy_q);
  // R3
  coarse_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> toa_q[TOA_W-1 -: COARSE_W] == $past(coarse_i));
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] q_q;

  assign q_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q_q <= '0;
    else if (clr_i)               q_q <= inc_i ? W'(1) : '0;
    else if (inc_i && q_q != MAX) q_q <= q_q + W'(1);
  end

  // R4 R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q == MAX && !clr_i |=> q_q == MAX);
endmodule

// File: rtl/toa_tot_pixel.sv
module toa_tot_pixel
  import toa_tot_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 4,
  parameter int TOT_W    = 10,
  parameter int CNT_W    = 4,
  localparam int TOA_W   = COARSE_W + FINE_W,
  localparam int HI_W    = (TOA_W > TOT_W) ? TOA_W : TOT_W,
  localparam int LO_W    = (TOT_W > CNT_W) ? TOT_W : CNT_W,
  localparam int WORD_W  = 2 + HI_W + LO_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_edge_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                hit_i,
  input  logic [1:0]          mode_i,
  input  logic                ack_i,
  output logic                osc_req_o,
  output logic                ready_o,
  output logic [WORD_W-1:0]   data_o
);
  pix_st_e           st_q, st_d;
  logic              hit_q, rise, accept, fin, measuring, arr_done;
  logic [TOA_W-1:0]  toa;
  logic [TOT_W-1:0]  tot;
  logic [CNT_W-1:0]  evt;
  logic [HI_W-1:0]   hi;
  logic [LO_W-1:0]   lo;
  logic [WORD_W-1:0] data_q;

  assign rise      = hit_i & ~hit_q;
  assign accept    = (st_q == ST_IDLE) & rise;
  assign fin       = (st_q == ST_DUR) & ~hit_i;
  assign measuring = accept | (st_q == ST_ARR) | (st_q == ST_DUR);

  tdc_fine #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_fine (
    .clk_i, .rst_ni,
    .start_i   (accept),
    .ref_edge_i,
    .coarse_i,
    .done_o    (arr_done),
    .osc_req_o,
    .toa_o     (toa)
  );

  sat_cnt #(.W(TOT_W)) u_tot (
    .clk_i, .rst_ni,
    .clr_i (accept),
    .inc_i (measuring & ref_edge_i & hit_i),
    .q_o   (tot)
  );

  sat_cnt #(.W(CNT_W)) u_evt (
    .clk_i, .rst_ni,
    .clr_i (fin),
    .inc_i (rise),
    .q_o   (evt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)   st_d = arr_done ? ST_DUR : ST_ARR;
      ST_ARR:  if (arr_done) st_d = ST_DUR;
      ST_DUR:  if (!hit_i)   st_d = ST_HOLD;
      ST_HOLD: if (ack_i)    st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (pair_e'(mode_i))
      PAIR_TOA_CNT: begin hi = HI_W'(toa); lo = LO_W'(evt); end
      PAIR_TOT_CNT: begin hi = HI_W'(tot); lo = LO_W'(evt); end
      default:      begin hi = HI_W'(toa); lo = LO_W'(tot); end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q  <= st_d;
      hit_q <= hit_i;
      if (fin) data_q <= {mode_i, hi, lo};
    end
  end

  assign ready_o = (st_q == ST_HOLD);
  assign data_o  = data_q;

  // R7
  hold_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !ack_i |=> ready_o && $stable(data_o));
  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && ack_i |=> !ready_o);
  // R6
  end_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !$past(hit_i));
  // R5
  evt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> evt == '0);
  // R8
  no_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !osc_req_o);
endmodule

// File: tb/sim_toa_tot_pixel.sv
module sim_toa_tot_pixel;
  localparam int CW = 8, FW = 4, TW = 6, NW = 3;
  localparam int WW = 2 + 12 + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit = 1'b0, ack = 1'b0;
  logic [1:0] mode_r = 2'd0;
  int cyc = 0;
  logic ref_edge;
  logic [CW-1:0] coarse;
  logic osc, ready;
  logic [WW-1:0] data;

  int nchk = 0, nerr = 0;
  int pend = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign ref_edge = (cyc % 16 == 0);
  assign coarse   = CW'((cyc / 16) % 256);

  toa_tot_pixel #(.COARSE_W(CW), .FINE_W(FW), .TOT_W(TW), .CNT_W(NW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_edge), .coarse_i(coarse),
    .hit_i(hit), .mode_i(mode_r), .ack_i(ack),
    .osc_req_o(osc), .ready_o(ready), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic longint mk_word(int md, int toa, int tot, int evt);
    int hi, lo;
    hi = (md == 2) ? tot : toa;
    lo = (md == 1 || md == 2) ? evt : tot;
    return (longint'(md) << 18) | (longint'(hi) << 6) | longint'(lo);
  endfunction

  // behavioural reference, advanced on every clock
  int m_st, m_h, m_toa, m_tot, m_evt;
  bit m_prev, m_ready, m_osc;
  longint m_data;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tot = 0; m_evt = 0; m_toa = 0; m_h = 0;
      m_prev = 0; m_ready = 0; m_osc = 0; m_data = 0;
    end else begin
      bit r, e;
      r = hit && !m_prev;
      m_prev = hit;
      e = (cyc % 16 == 0);
      if (r && m_evt < 7) m_evt++;
      case (m_st)
        0: if (r) begin
             m_h = cyc; m_tot = e ? 1 : 0;
             if (e) begin m_toa = ((cyc / 16) % 256) * 16 + 15; m_st = 2; end
             else m_st = 1;
           end
        1: begin
             if (e && hit && m_tot < 63) m_tot++;
             if (e) begin m_toa = ((cyc / 16) % 256) * 16 + 15 - (cyc - m_h); m_st = 2; end
           end
        2: if (!hit) begin
             m_data = mk_word(int'(mode_r), m_toa, m_tot, m_evt);
             m_evt = 0; m_st = 3;
           end else if (e && m_tot < 63) m_tot++;
        default: if (ack) m_st = 0;
      endcase
      m_ready = (m_st == 3);
      m_osc   = (m_st == 1);
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    chk(ready == m_ready, "R6 ready", ready, m_ready);
    chk(longint'(data) == m_data, "R10 word", data, m_data);
    chk(osc == m_osc, "R9 osc_req", osc, m_osc);
  end

  task automatic run_hit(int phase, int len, int md, int nign);
    int c, e, fine, crs, tot, evt, wait_n, toa;
    longint d0;
    mode_r = 2'(md);
    @(negedge clk);
    while (cyc % 16 != phase) @(negedge clk);
    c = cyc;
    hit = 1'b1;
    repeat (len) @(negedge clk);
    hit = 1'b0;
    e    = ((c + 15) / 16) * 16;
    fine = 15 - (e - c);
    crs  = (e / 16) % 256;
    toa  = crs * 16 + fine;
    tot  = (c + len - 1) / 16 - (c - 1) / 16;
    if (tot > 63) tot = 63;
    evt  = (1 + pend > 7) ? 7 : 1 + pend;
    wait_n = 0;
    while (!ready && wait_n < 3000) begin @(negedge clk); wait_n++; end
    chk(ready == 1'b1, "R6 ready after hit", ready, 1);
    chk(data[19:18] == 2'(md), "R10 pair field", data[19:18], md);
    if (md != 2) begin
      chk(data[9:6] == 4'(fine), "R2 fine", data[9:6], fine);
      chk(data[17:10] == 8'(crs), "R3 coarse", data[17:10], crs);
    end
    if (md == 0 || md == 3) chk(data[5:0] == 6'(tot), "R4 duration", data[5:0], tot);
    if (md == 2) chk(data[17:6] == 12'(tot), "R4 duration", data[17:6], tot);
    if (md == 1 || md == 2) chk(data[5:0] == 6'(evt), "R5 events", data[5:0], evt);
    chk(longint'(data) == mk_word(md, toa, tot, evt), "R10 word", data, mk_word(md, toa, tot, evt));
    d0 = longint'(data);
    for (int i = 0; i < nign; i++) begin
      hit = 1'b1; repeat (2) @(negedge clk);
      hit = 1'b0; repeat (2) @(negedge clk);
    end
    chk(longint'(data) == d0, "R8 ignored hits", data, d0);
    chk(ready == 1'b1, "R7 ready held", ready, 1);
    pend = nign;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(ready == 1'b0, "R7 ack clears", ready, 0);
    chk(longint'(data) == d0, "R7 word kept", data, d0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready", ready, 0);
    chk(osc == 1'b0, "R1 osc_req", osc, 0);
    chk(data == '0, "R1 data", data, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    run_hit(0, 5, 0, 0);
    run_hit(1, 20, 0, 2);
    for (int p = 2; p < 16; p++) run_hit(p, 3 + p, p % 4, p % 3);
    run_hit(3, 2, 0, 0);
    run_hit(5, 1100, 0, 0);
    run_hit(4, 10, 1, 9);
    run_hit(6, 10, 2, 0);
    repeat (4200) @(negedge clk);
    run_hit(7, 40, 3, 0);
    run_hit(9, 33, 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule